// File: doc/BRIEF.md
# ADC Result Register Read-Lock Interface

This block keeps the latest 10-bit conversion result and shows it to a processor bus as two byte-wide registers: a high byte and a low byte. Both registers are read-only. A control input sets the alignment. Right alignment puts the value in the low-order bits of the 16-bit pair. Left alignment puts it in the high-order bits, so a single high-byte read gives the 8 most significant bits.

Software that needs all ten bits reads the low byte first and then the high byte. The low-byte read freezes the stored value. Any conversion that completes before the high-byte read is discarded and is not queued. This guarantees that both bytes come from the same conversion. The block does not sign-extend or otherwise interpret the value, so a two's-complement result from a differential measurement is stored and presented exactly as received. The value is formatted when it is read, not when it is captured, so switching the alignment re-presents the stored value without a new conversion.

Top module: `adc_result_lock`

## Requirements
- R1: After reset, both byte registers read as 0x00 and the lock is clear.
- R2: With `left_adj_i`=0, address 0 (low byte) reads result[7:0]. Address 1 (high byte) reads {6'b0, result[9:8]}.
- R3: With `left_adj_i`=1, address 1 reads result[9:2]. Address 0 reads {result[1:0], 6'b0}.
- R4: While unlocked, a `conv_done_i` pulse stores `conv_result_i` at that clock edge, and reads in the next cycle return it.
- R5: A read of address 0 (`bus_req_i`=1, `bus_we_i`=0) sets the lock. While locked, every completed conversion is discarded and is not queued.
- R6: The high-byte read that clears the lock returns the frozen value. A conversion in that same cycle is discarded. Conversions are accepted again from the next cycle.
- R7: A high-byte read without a preceding low-byte read sets no lock, so the next conversion is stored.
- R8: Changing `left_adj_i` re-formats the stored value combinationally, with no new conversion needed.
- R9: An access with `bus_we_i`=1 to either address changes neither the stored value nor the lock.
- R10: Two's-complement (differential) results are stored and presented bit-exact, with no sign extension into the pad bits.
- R11: A conversion that completes in the same cycle as a low-byte read is discarded. The following high-byte read therefore returns the older value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| conv_done_i | input | 1 | Conversion-complete strobe, one cycle |
| conv_result_i | input | 10 | Conversion result, valid with the strobe |
| left_adj_i | input | 1 | 1 = left-aligned, 0 = right-aligned |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Access is a write (ignored) |
| bus_addr_i | input | 1 | Byte select: 0 = low byte, 1 = high byte |
| rd_data_o | output | 8 | Selected byte, formatted (combinational) |

## Verification
A lock bit that sticks set shows up as a result that never changes after a low-byte read. A lock bit that never sets shows up as a high byte taken from a newer conversion than the low byte. Either fault appears on the first read pair after the triggering access. Wrong alignment or pad bits appear on the very next read. The bench therefore interleaves conversions with reads cycle by cycle, including conversions in the same cycle as the low-byte and high-byte reads. It checks every byte returned against values computed from the alignment rules.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;
  localparam int unsigned RES_W  = 10;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    SEL_LO = 1'b0,
    SEL_HI = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/adc_res_decode.sv
module adc_res_decode (
  input  logic bus_req_i,
  input  logic bus_we_i,
  input  logic bus_addr_i,
  output logic rd_lo_o,
  output logic rd_hi_o
);
  import adc_res_pkg::*;

  logic rd_any;

  // writes never touch the register pair
  assign rd_any  = bus_req_i && !bus_we_i;
  assign rd_lo_o = rd_any && (bus_addr_i == SEL_LO);
  assign rd_hi_o = rd_any && (bus_addr_i == SEL_HI);
endmodule

// File: rtl/adc_res_store.sv
module adc_res_store #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_result_i,
  input  logic             rd_lo_i,
  input  logic             rd_hi_i,
  output logic [RES_W-1:0] result_o,
  output logic             locked_o
);
  logic [RES_W-1:0] res_q;
  logic             lock_q, lock_d, take;

  // a low read freezes the pair from its own cycle on
  assign take = conv_done_i && !lock_q && !rd_lo_i;

  always_comb begin
    lock_d = lock_q;
    if (rd_hi_i)      lock_d = 1'b0;
    else if (rd_lo_i) lock_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      lock_q <= lock_d;
      if (take) res_q <= conv_result_i;
    end
  end

  assign result_o = res_q;
  assign locked_o = lock_q;

  // R4
  take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done_i && !lock_q && !rd_lo_i) |=> (res_q == $past(conv_result_i)));

  // R5
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(res_q));

  // R5
  lock_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_i |=> lock_q);

  // R6
  unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hi_i |=> !lock_q);

  // R11
  same_cycle_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_i |=> $stable(res_q));

  // R9
  lock_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_lo_i && !rd_hi_i) |=> $stable(lock_q));
endmodule

// File: rtl/adc_res_align.sv
module adc_res_align #(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [RES_W-1:0]  value_i,
  input  logic              left_adj_i,
  input  logic              sel_hi_i,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int unsigned PAIR_W = 2 * BYTE_W;
  localparam int unsigned PAD_W  = PAIR_W - RES_W;

  logic [PAIR_W-1:0] pair;

  generate
    if (PAD_W == 0) begin : g_full
      assign pair = value_i;
    end else begin : g_pad
      // pad to the right for left alignment, to the left otherwise
      assign pair = left_adj_i ? {value_i, {PAD_W{1'b0}}}
                               : {{PAD_W{1'b0}}, value_i};
    end
  endgenerate

  assign byte_o = sel_hi_i ? pair[PAIR_W-1:BYTE_W] : pair[BYTE_W-1:0];
endmodule

// File: rtl/adc_result_lock.sv
module adc_result_lock #(
  parameter int unsigned RES_W  = adc_res_pkg::RES_W,
  parameter int unsigned BYTE_W = adc_res_pkg::BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_result_i,
  input  logic              left_adj_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic              bus_addr_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  import adc_res_pkg::*;

  localparam int unsigned PAD_W = 2 * BYTE_W - RES_W;

  logic             rd_lo, rd_hi, locked;
  logic [RES_W-1:0] stored;

  adc_res_decode i_decode (
    .bus_req_i  (bus_req_i),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .rd_lo_o    (rd_lo),
    .rd_hi_o    (rd_hi)
  );

  adc_res_store #(.RES_W(RES_W)) i_store (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .conv_done_i   (conv_done_i),
    .conv_result_i (conv_result_i),
    .rd_lo_i       (rd_lo),
    .rd_hi_i       (rd_hi),
    .result_o      (stored),
    .locked_o      (locked)
  );

  adc_res_align #(.RES_W(RES_W), .BYTE_W(BYTE_W)) i_align (
    .value_i    (stored),
    .left_adj_i (left_adj_i),
    .sel_hi_i   (bus_addr_i == SEL_HI),
    .byte_o     (rd_data_o)
  );

  // R6
  hi_read_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && rd_hi) |=> $stable(stored));

  generate
    if (PAD_W > 0) begin : g_pad_chk
      // R3
      left_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (left_adj_i && bus_addr_i == SEL_LO) |-> (rd_data_o[PAD_W-1:0] == '0));
      // R10
      right_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!left_adj_i && bus_addr_i == SEL_HI) |-> (rd_data_o[BYTE_W-1:BYTE_W-PAD_W] == '0));
    end
  endgenerate
endmodule

// File: tb/test_adc_result_lock.sv
module test_adc_result_lock;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       done = 1'b0;
  logic [9:0] res = '0;
  logic       left = 1'b0;
  logic       req = 1'b0;
  logic       we = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] rd;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  adc_result_lock i_adc_result_lock (
    .clk_i(clk), .rst_ni(rst_n), .conv_done_i(done), .conv_result_i(res),
    .left_adj_i(left), .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .rd_data_o(rd)
  );

  // {left, result, hi, lo}
  localparam logic [26:0] VECS [8] = '{
    {1'b0, 10'h3FF, 8'h03, 8'hFF},
    {1'b1, 10'h3FF, 8'hFF, 8'hC0},
    {1'b0, 10'h2A5, 8'h02, 8'hA5},
    {1'b1, 10'h2A5, 8'hA9, 8'h40},
    {1'b0, 10'h155, 8'h01, 8'h55},
    {1'b1, 10'h155, 8'h55, 8'h40},
    {1'b1, 10'h201, 8'h80, 8'h40},
    {1'b0, 10'h000, 8'h00, 8'h00}
  };

  function automatic logic [7:0] exp_byte(input logic [9:0] v, input logic l, input logic hi);
    if (l) return hi ? v[9:2] : {v[1:0], 6'b0};
    return hi ? {6'b0, v[9:8]} : v[7:0];
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // one cycle: drive after negedge, capture combinational read data, wait next negedge
  task automatic op(input logic d, input logic [9:0] r, input logic q, input logic w,
                    input logic a, output logic [7:0] data);
    done = d; res = r; req = q; we = w; addr = a;
    #1 data = rd;
    @(negedge clk);
    done = 1'b0; req = 1'b0; we = 1'b0;
  endtask

  task automatic conv(input logic [9:0] r);
    logic [7:0] dummy;
    op(1'b1, r, 1'b0, 1'b0, 1'b0, dummy);
  endtask

  task automatic rd_pair(output logic [7:0] lo, output logic [7:0] hi);
    op(1'b0, '0, 1'b1, 1'b0, 1'b0, lo);
    op(1'b0, '0, 1'b1, 1'b0, 1'b1, hi);
  endtask

  initial begin
    #1600000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] lo, hi;
    @(negedge clk); @(negedge clk);
    // R1 reset state, sampled while reset is still held
    addr = 1'b0; #1 chk("R1 lo", rd, 8'h00);
    addr = 1'b1; #1 chk("R1 hi", rd, 8'h00);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);

    // R2 R3 R4 table walk
    for (int i = 0; i < 8; i++) begin
      left = VECS[i][26];
      conv(VECS[i][25:16]);
      rd_pair(lo, hi);
      chk($sformatf("R4 vec%0d hi", i), hi, VECS[i][15:8]);
      chk($sformatf("R2/R3 vec%0d lo", i), lo, VECS[i][7:0]);
    end

    // R5 conversions during lock are dropped, not queued
    left = 1'b0;
    conv(10'h123);
    op(1'b0, '0, 1'b1, 1'b0, 1'b0, lo);
    conv(10'h2DE);
    conv(10'h0F0);
    op(1'b0, '0, 1'b1, 1'b0, 1'b1, hi);
    chk("R5 lo frozen", lo, 8'h23);
    chk("R5 hi frozen", hi, 8'h01);
    rd_pair(lo, hi);
    chk("R5 not queued lo", lo, 8'h23);
    chk("R5 not queued hi", hi, 8'h01);

    // R6 conversion in the unlocking cycle dropped, next cycle accepted
    op(1'b0, '0, 1'b1, 1'b0, 1'b0, lo);
    op(1'b1, 10'h3AA, 1'b1, 1'b0, 1'b1, hi);
    chk("R6 hi returns frozen", hi, 8'h01);
    rd_pair(lo, hi);
    chk("R6 same-cycle conv dropped", lo, 8'h23);
    op(1'b0, '0, 1'b1, 1'b0, 1'b0, lo);
    op(1'b0, '0, 1'b1, 1'b0, 1'b1, hi);
    conv(10'h1C7);
    rd_pair(lo, hi);
    chk("R6 accepted after unlock lo", lo, exp_byte(10'h1C7, 1'b0, 1'b0));
    chk("R6 accepted after unlock hi", hi, exp_byte(10'h1C7, 1'b0, 1'b1));

    // R7 high-only read sets no lock
    left = 1'b1;
    op(1'b0, '0, 1'b1, 1'b0, 1'b1, hi);
    chk("R7 hi-only value", hi, exp_byte(10'h1C7, 1'b1, 1'b1));
    conv(10'h2F3);
    op(1'b0, '0, 1'b1, 1'b0, 1'b1, hi);
    chk("R7 new conv after hi-only", hi, exp_byte(10'h2F3, 1'b1, 1'b1));

    // R8 alignment toggle re-presents stored value
    left = 1'b0;
    rd_pair(lo, hi);
    chk("R8 right lo", lo, exp_byte(10'h2F3, 1'b0, 1'b0));
    chk("R8 right hi", hi, exp_byte(10'h2F3, 1'b0, 1'b1));
    left = 1'b1;
    rd_pair(lo, hi);
    chk("R8 left lo", lo, exp_byte(10'h2F3, 1'b1, 1'b0));
    chk("R8 left hi", hi, exp_byte(10'h2F3, 1'b1, 1'b1));

    // R9 write to low byte sets no lock
    op(1'b0, '0, 1'b1, 1'b1, 1'b0, lo);
    conv(10'h0A5);
    op(1'b0, '0, 1'b1, 1'b0, 1'b1, hi);
    chk("R9 write no lock", hi, exp_byte(10'h0A5, 1'b1, 1'b1));
    // R9 write to high byte does not unlock
    op(1'b0, '0, 1'b1, 1'b0, 1'b0, lo);
    op(1'b0, '0, 1'b1, 1'b1, 1'b1, hi);
    conv(10'h35A);
    op(1'b0, '0, 1'b1, 1'b0, 1'b1, hi);
    chk("R9 write no unlock", hi, exp_byte(10'h0A5, 1'b1, 1'b1));

    // R10 two's-complement -2 bit-exact in both alignments
    conv(10'h3FE);
    left = 1'b0;
    rd_pair(lo, hi);
    chk("R10 right lo", lo, 8'hFE);
    chk("R10 right hi", hi, 8'h03);
    left = 1'b1;
    rd_pair(lo, hi);
    chk("R10 left lo", lo, 8'h80);
    chk("R10 left hi", hi, 8'hFF);

    // R11 conversion coincident with low read is dropped
    left = 1'b0;
    conv(10'h0C3);
    op(1'b1, 10'h33C, 1'b1, 1'b0, 1'b0, lo);
    op(1'b0, '0, 1'b1, 1'b0, 1'b1, hi);
    chk("R11 lo old", lo, 8'hC3);
    chk("R11 hi old", hi, 8'h00);

    // R1 reset mid-lock clears value and lock
    op(1'b0, '0, 1'b1, 1'b0, 1'b0, lo);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    addr = 1'b0; #1 chk("R1 after reset lo", rd, 8'h00);
    @(negedge clk);
    conv(10'h2B4);
    op(1'b0, '0, 1'b1, 1'b0, 1'b0, lo);
    chk("R1 lock cleared by reset", lo, 8'hB4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule